// File: doc/BRIEF.md
# Prime-Factor Fraction Reducer

This block shrinks a 64-bit numerator/denominator pair by stripping the small prime factors the two values share. It walks a fixed list of primes in ascending order. For each prime it keeps dividing both values while both remain exactly divisible, then moves on to the next prime. A typical use is to bring a phase/modulo ratio for a fractional clock synthesizer within 32 bits per term without changing the ratio. It does not compute a full greatest common divisor, so factors above the table's largest prime survive.

An operation enters through a valid/ready pair. The operands and a bound-check mode bit are taken in the cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from that cycle until the result is published, so an upstream producer must hold its request. The output side has no back-pressure: a single-cycle `out_done` pulse marks new results, and the results stay on their ports until the next pulse. In bound-check mode the block stops as soon as both values fit in 32 bits. If the list runs out first, it reports failure and still returns the partly reduced pair.

Top module: `fraction_reducer`

## Requirements
- R1: An operand pair is taken only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is low from the cycle after acceptance until `out_done` pulses, and `in_valid` activity while busy has no effect on the result.
- R2: The trial divisors are the 168 primes from 2 to 997, tried in ascending order, so a shared factor such as 991 or 997 is removed.
- R3: For the current prime, both values are divided again and again while both are exact multiples of it. The block then moves to the next prime.
- R4: When `in_bound_chk` is 1, both values are tested before each prime. If both are at most 0xFFFFFFFF, the block stops at once with `out_ok` = 1.
- R5: When `in_bound_chk` is 0, every prime is processed and `out_ok` = 1.
- R6: When `in_bound_chk` is 1 and the list runs out before a passing test, `out_ok` = 0. This holds even if the values fit after the division by 997, and the partly reduced values are still output.
- R7: If both values are zero, each prime causes only one division, so the operation ends with 0/0. If only one value is zero, the loop is bounded by the other value.
- R8: `out_done` is high for exactly one cycle per operation. `out_num`, `out_den` and `out_ok` change only in that cycle and are held until the next pulse.
- R9: During reset `in_ready` = 1, `out_done` = 0, and `out_num`, `out_den` and `out_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take a pair |
| in_num | input | VAL_W | Numerator operand |
| in_den | input | VAL_W | Denominator operand |
| in_bound_chk | input | 1 | 1: stop early once both fit in FIT_W bits |
| out_done | output | 1 | One-cycle pulse: results updated |
| out_num | output | VAL_W | Reduced numerator |
| out_den | output | VAL_W | Reduced denominator |
| out_ok | output | 1 | Success flag |

## Verification
The bench builds the block with the default 64-bit operands and 32-bit fit bound. It raises the remainder unit to 8 quotient bits per cycle, so a full 168-prime pass takes about two thousand cycles. This makes whole-table runs affordable: exhaustion after the last prime, both-zero operands and shared factors of 991 and 997. The stimulus also covers early exit on the first test, values that fit only after several divisions by 2, and the 0xFFFFFFFF edge.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int PRIME_W   = 10;
  localparam int PRIME_CNT = 168;
  localparam int PRIME_TOP = 997;
  localparam int ROM_BITS  = PRIME_CNT * PRIME_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TEST,
    ST_TRIAL
  } fr_state_e;

  // Ascending primes packed LSB-first, computed at elaboration.
  function automatic logic [ROM_BITS-1:0] build_prime_rom();
    logic [ROM_BITS-1:0] tbl;
    int fill;
    bit is_p;
    tbl  = '0;
    fill = 0;
    for (int c = 2; c <= PRIME_TOP; c++) begin
      is_p = 1'b1;
      for (int f = 2; f * f <= c; f++) begin
        if (c % f == 0) is_p = 1'b0;
      end
      if (is_p && fill < PRIME_CNT) begin
        tbl[fill*PRIME_W +: PRIME_W] = PRIME_W'(c);
        fill++;
      end
    end
    return tbl;
  endfunction
endpackage

// File: rtl/fr_prime_rom.sv
module fr_prime_rom
  import fr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [PRIME_W-1:0] prime
);
  localparam logic [ROM_BITS-1:0] TABLE = build_prime_rom();

  logic [PRIME_W-1:0] entry [PRIME_CNT];

  for (genvar g = 0; g < PRIME_CNT; g++) begin : g_entry
    assign entry[g] = TABLE[g*PRIME_W +: PRIME_W];
  end

  always_comb begin
    prime = '0;
    for (int i = 0; i < PRIME_CNT; i++) begin
      if (int'(idx) == i) prime = entry[i];
    end
  end
endmodule

// File: rtl/fr_rem_unit.sv
module fr_rem_unit #(
  parameter int DATA_W     = 64,
  parameter int DIV_W      = 10,
  parameter int RADIX_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] quotient,
  output logic [DIV_W-1:0]  remainder,
  output logic              done
);
  localparam int STEPS = DATA_W / RADIX_BITS;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [DATA_W-1:0]     work_q;
  logic [DIV_W-1:0]      rem_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  done_q;
  logic [DIV_W-1:0]      r_chain [RADIX_BITS+1];
  logic [RADIX_BITS-1:0] q_bits;

  assign r_chain[0] = rem_q;

  // One restoring-division stage per quotient bit retired this cycle.
  for (genvar g = 0; g < RADIX_BITS; g++) begin : g_stage
    logic [DIV_W:0] trial;
    logic [DIV_W:0] diff;
    logic           take;
    assign trial = {r_chain[g], work_q[DATA_W-1-g]};
    assign diff  = trial - {1'b0, divisor};
    assign take  = (trial >= {1'b0, divisor});
    assign q_bits[RADIX_BITS-1-g] = take;
    assign r_chain[g+1] = take ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      work_q <= dividend;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(STEPS);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      work_q <= {work_q[DATA_W-1-RADIX_BITS:0], q_bits};
      rem_q  <= r_chain[RADIX_BITS];
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quotient  = work_q;
  assign remainder = rem_q;
  assign done      = done_q;
endmodule

// File: rtl/fraction_reducer.sv
module fraction_reducer
  import fr_pkg::*;
#(
  parameter int VAL_W      = 64,
  parameter int FIT_W      = 32,
  parameter int RADIX_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VAL_W-1:0] in_num,
  input  logic [VAL_W-1:0] in_den,
  input  logic             in_bound_chk,
  output logic             out_done,
  output logic [VAL_W-1:0] out_num,
  output logic [VAL_W-1:0] out_den,
  output logic             out_ok
);
  localparam int IDX_W = $clog2(PRIME_CNT + 1);
  localparam int NOPS  = 2;

  fr_state_e           state_q;
  logic [VAL_W-1:0]    num_q, den_q;
  logic                chk_q;
  logic [IDX_W-1:0]    idx_q;
  logic                div_start_q;
  logic [PRIME_W-1:0]  cur_prime;
  logic                fits;
  logic                table_end;

  logic [VAL_W-1:0]    opnd   [NOPS];
  logic [VAL_W-1:0]    quo    [NOPS];
  logic [PRIME_W-1:0]  rem    [NOPS];
  logic [NOPS-1:0]     dv_done;

  fr_prime_rom #(.IDX_W(IDX_W)) u_rom (
    .idx   (idx_q),
    .prime (cur_prime)
  );

  assign opnd[0] = num_q;
  assign opnd[1] = den_q;

  for (genvar g = 0; g < NOPS; g++) begin : g_div
    fr_rem_unit #(
      .DATA_W     (VAL_W),
      .DIV_W      (PRIME_W),
      .RADIX_BITS (RADIX_BITS)
    ) u_rem (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (div_start_q),
      .dividend  (opnd[g]),
      .divisor   (cur_prime),
      .quotient  (quo[g]),
      .remainder (rem[g]),
      .done      (dv_done[g])
    );
  end

  assign fits      = (num_q[VAL_W-1:FIT_W] == '0) && (den_q[VAL_W-1:FIT_W] == '0);
  assign table_end = (idx_q == IDX_W'(PRIME_CNT));
  assign in_ready  = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      num_q       <= '0;
      den_q       <= '0;
      chk_q       <= 1'b0;
      idx_q       <= '0;
      div_start_q <= 1'b0;
      out_done    <= 1'b0;
      out_num     <= '0;
      out_den     <= '0;
      out_ok      <= 1'b0;
    end else begin
      out_done    <= 1'b0;
      div_start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            num_q   <= in_num;
            den_q   <= in_den;
            chk_q   <= in_bound_chk;
            idx_q   <= '0;
            state_q <= ST_TEST;
          end
        end
        ST_TEST: begin
          // List end is tested first: no fit test follows the last prime.
          if (table_end) begin
            out_num  <= num_q;
            out_den  <= den_q;
            out_ok   <= !chk_q;
            out_done <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (chk_q && fits) begin
            out_num  <= num_q;
            out_den  <= den_q;
            out_ok   <= 1'b1;
            out_done <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            div_start_q <= 1'b1;
            state_q     <= ST_TRIAL;
          end
        end
        ST_TRIAL: begin
          if (dv_done[0]) begin
            if (rem[0] == '0 && rem[1] == '0) begin
              num_q <= quo[0];
              den_q <= quo[1];
              if (num_q == '0 && den_q == '0) begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_TEST;
              end else begin
                div_start_q <= 1'b1;
              end
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_TEST;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int VAL_W = 64,
  parameter int FIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_done,
  input logic [VAL_W-1:0] out_num,
  input logic [VAL_W-1:0] out_den,
  input logic             out_ok,
  input logic             chk_q
);
  // R1: acceptance makes the block busy on the next cycle
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R1: results publish returns the block to idle
  a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);

  // R8: completion strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R8: results hold between strobes
  a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_num) && $stable(out_den) && $stable(out_ok)));

  // R5: without bound check success is always reported
  a_r5_nocheck_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !chk_q) |-> out_ok);

  // R4: a checked success means both values fit
  a_r4_fit_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && chk_q && out_ok) |->
      (out_num[VAL_W-1:FIT_W] == '0 && out_den[VAL_W-1:FIT_W] == '0));
endmodule

bind fraction_reducer fr_checker #(.VAL_W(VAL_W), .FIT_W(FIT_W)) u_fr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_done (out_done),
  .out_num  (out_num),
  .out_den  (out_den),
  .out_ok   (out_ok),
  .chk_q    (chk_q)
);

// File: tb/fraction_reducer_bench.sv
module fraction_reducer_bench;
  localparam int VAL_W = 64;
  localparam int NVEC  = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [VAL_W-1:0] in_num = '0;
  logic [VAL_W-1:0] in_den = '0;
  logic             in_bound_chk = 1'b0;
  logic             out_done;
  logic [VAL_W-1:0] out_num, out_den;
  logic             out_ok;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  fraction_reducer #(.VAL_W(64), .FIT_W(32), .RADIX_BITS(8)) u_fraction_reducer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_den(in_den), .in_bound_chk(in_bound_chk),
    .out_done(out_done), .out_num(out_num), .out_den(out_den), .out_ok(out_ok)
  );

  // {bound_chk, numerator, denominator}
  localparam logic [128:0] VEC [NVEC] = '{
    {1'b1, 64'd6, 64'd4},                                  // R4 immediate exit
    {1'b0, 64'd6, 64'd4},                                  // R5 R3 -> 3/2
    {1'b0, 64'd9895604649984, 64'd721554505728},           // R3 powers of 2 and 3
    {1'b1, 64'd42949672960, 64'd85899345920},              // R4 fits after 2s
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000},      // R6 no shared factor
    {1'b1, 64'd988053892081, 64'd1982053946},              // R6 fits only after 997
    {1'b0, 64'd988053892081, 64'd1982053946},              // R2 R5 997 removed
    {1'b0, 64'd6916189, 64'd10868297},                     // R2 991 and 997
    {1'b0, 64'd0, 64'd0},                                  // R7 both zero
    {1'b0, 64'd0, 64'd12},                                 // R7 one zero
    {1'b1, 64'hFFFF_FFFF, 64'hFFFF_FFFF},                  // R4 boundary value
    {1'b1, 64'h1_0000_0000, 64'd2}                         // R4 one over boundary
  };

  function automatic bit is_prime(input int c);
    for (int f = 2; f * f <= c; f++) if (c % f == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model(input logic [63:0] n, input logic [63:0] d, input bit chk,
                       output logic [63:0] rn, output logic [63:0] rd, output bit ok);
    rn = n; rd = d; ok = !chk;
    for (int p = 2; p <= 997; p++) begin
      if (is_prime(p)) begin
        if (chk && rn <= 64'hFFFF_FFFF && rd <= 64'hFFFF_FFFF) begin
          ok = 1'b1;
          return;
        end
        while ((rn % p) == 0 && (rd % p) == 0) begin
          if (rn == 0 && rd == 0) break;
          rn = rn / p; rd = rd / p;
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] n, input logic [63:0] d, input bit chk);
    int guard;
    @(negedge clk);
    in_valid = 1'b1; in_num = n; in_den = d; in_bound_chk = chk;
    @(negedge clk);
    in_valid = 1'b0;
    guard = 0;
    while (!out_done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (!out_done) check("R8 done timeout", 64'd0, 64'd1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] en, ed;
    logic [63:0] hn, hd;
    bit eo;
    logic ho;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 in_ready", 64'(in_ready), 64'd1);
    check("R9 out_done", 64'(out_done), 64'd0);
    check("R9 out_num", out_num, 64'd0);
    check("R9 out_ok", 64'(out_ok), 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      model(VEC[v][127:64], VEC[v][63:0], VEC[v][128], en, ed, eo);
      run_op(VEC[v][127:64], VEC[v][63:0], VEC[v][128]);
      check($sformatf("R3 num vec%0d", v), out_num, en);
      check($sformatf("R3 den vec%0d", v), out_den, ed);
      check($sformatf("R4 R5 R6 ok vec%0d", v), 64'(out_ok), 64'(eo));
    end

    // R6 quirk: fits after 997 yet fails, partial values 997/2
    run_op(64'd988053892081, 64'd1982053946, 1'b1);
    check("R6 quirk ok", 64'(out_ok), 64'd0);
    check("R6 quirk num", out_num, 64'd997);
    check("R6 quirk den", out_den, 64'd2);

    // R1: requests while busy are ignored
    @(negedge clk);
    in_valid = 1'b1; in_num = 64'd6; in_den = 64'd4; in_bound_chk = 1'b0;
    @(negedge clk);
    in_num = 64'd35; in_den = 64'd49;
    repeat (20) begin
      @(negedge clk);
      check("R1 busy not ready", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
    while (!out_done) @(negedge clk);
    check("R1 first op num", out_num, 64'd3);
    check("R1 first op den", out_den, 64'd2);

    // R8: single pulse, results held
    hn = out_num; hd = out_den; ho = out_ok;
    repeat (5) begin
      @(negedge clk);
      check("R8 done low", 64'(out_done), 64'd0);
      check("R8 num held", out_num, hn);
      check("R8 den held", out_den, hd);
      check("R8 ok held", 64'(out_ok), 64'(ho));
    end
    check("R1 ready again", 64'(in_ready), 64'd1);

    finish_run();
  end
endmodule